// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs into two 32-bit pending words and gates them with two 32-bit enable words. The words are called "upper" and "lower". A source number does not map to the bit of the same number. Each source lands on a fixed word and bit position given by a scattered assignment. Software must use this assignment when it enables a source or acknowledges one.

A processor reaches the block through a plain register port with a byte address, a write strobe, write data and combinational read data. A single request line tells the processor that at least one enabled source is pending. A read-only vector register reports the lowest-numbered active source, counting from 1, packed into its top six bits. Three general storage registers, one configuration word and two priority words, hold the values software programs into them. These registers have no effect on the selection order.

Top module: `irqc_top`

## Requirements
- R1: Sources 0–15 and 32–47 live in the upper word. Source 0 uses bit 0. Source s in 1–15 uses bit 16−s. Source s in 32–47 uses bit 63−s.
- R2: Sources 16–31 and 48–63 live in the lower word. Source s in 16–18 uses bit 18−s. Source s in 19–30 uses bit 33−s. Source 31 uses bit 15. Source s in 48–63 uses bit s−32.
- R3: An enable bit of 1 lets its source request an interrupt, and a bit of 0 blocks it. Both enable words are zero after reset.
- R4: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. A write of all ones clears the whole word.
- R5: A pending bit is set in every cycle its input is sampled high, whatever its enable bit. This set takes precedence over a clear written in the same cycle, so a bit whose input stays high is pending again after it is cleared.
- R6: The vector register holds the selected source number in bits 31:26, and all its other bits read 0. Reading it changes nothing. Writes to it are ignored.
- R7: The vector reads 0 when no source from 1 to 63 is both pending and enabled.
- R8: Among the sources from 1 to 63 that are both pending and enabled, the one with the lowest number is reported. This holds across both words.
- R9: The request output is 1 exactly when some pending bit and its enable bit are both 1. This includes source 0.
- R10: The configuration word resets to 0. Both priority words reset to 0x05309770. All three read back what was last written.
- R11: The byte offsets are: configuration 0x00, upper priority 0x04, lower priority 0x08, upper pending 0x0C, lower pending 0x10, upper enable 0x14, lower enable 0x18, vector 0x1C. An access with address bits 1:0 not zero writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 64 | Interrupt input levels, indexed by source number |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench raises each of the 64 sources on its own and checks that exactly one bit appears in the correct word. A wrong entry in the scatter table shows up as a bit in the wrong place. Source 31 is included, so a design that puts it on bit 0 of the lower word, where it would collide with source 18, is caught.

The bench then sets several sources across both words together. It checks that the vector follows the lowest enabled number as sources are cleared one by one. An encoder that picks the highest number, or that scans each word separately, reports the wrong vector.

Other cases are targeted directly:
- A write-1-to-clear while the input is still high. A design that gives the clear priority loses a live level.
- A write of zero to a pending word. A design that stores the written value instead of clearing wipes out pending state.
- Source 0 alone. A design that encodes it must still report vector 0, yet must raise the request line.
- A write to the vector register and a misaligned write to an enable word. A design that decodes either one corrupts state.

// File: rtl/irqc_pkg.sv
// Package: shared constants, register selector and the fixed source scatter.
// Assumes exactly 64 sources split over two 32-bit words.
package irqc_pkg;

    localparam int NSRC   = 64;
    localparam int WORD_W = 32;
    localparam int NUM_W  = $clog2(NSRC);
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        SEL_CFG     = 3'd0,
        SEL_PRIO_UP = 3'd1,
        SEL_PRIO_LO = 3'd2,
        SEL_PEND_UP = 3'd3,
        SEL_PEND_LO = 3'd4,
        SEL_EN_UP   = 3'd5,
        SEL_EN_LO   = 3'd6,
        SEL_VEC     = 3'd7
    } reg_sel_e;

    // True when source s is held in the upper word.
    function automatic logic src_in_upper(int unsigned s);
        return ((s / 16) % 2) == 0;
    endfunction

    // Bit position of source s inside its word.
    function automatic logic [BIT_W-1:0] src_bit(int unsigned s);
        int unsigned r;
        case (s / 16)
            0:       r = (s == 0) ? 0 : 16 - s;
            1:       r = (s < 19) ? 18 - s : ((s < 31) ? 33 - s : 15);
            2:       r = 63 - s;
            default: r = s - 32;
        endcase
        return BIT_W'(r);
    endfunction

endpackage

// File: rtl/irqc_map.sv
// Module: translates between source-number order and the two register words.
// Scatter puts input levels into word positions; gather pulls word bits back
// into source order. Assumes the package table is a bijection.
module irqc_map
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]   src_lvl,
    input  logic [WORD_W-1:0] act_up,
    input  logic [WORD_W-1:0] act_lo,
    output logic [WORD_W-1:0] lvl_up,
    output logic [WORD_W-1:0] lvl_lo,
    output logic [NSRC-1:0]   act_src
);

    // Scatter: place each source level on its word bit.
    always_comb begin
        lvl_up = '0;
        lvl_lo = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_in_upper(s)) lvl_up[src_bit(s)] = src_lvl[s];
            else                 lvl_lo[src_bit(s)] = src_lvl[s];
        end
    end

    // Gather: read each source's active flag from its word bit.
    always_comb begin
        act_src = '0;
        for (int s = 0; s < NSRC; s++) begin
            act_src[s] = src_in_upper(s) ? act_up[src_bit(s)] : act_lo[src_bit(s)];
        end
    end

endmodule

// File: rtl/irqc_pend.sv
// Module: the pending word pair. Levels set bits each cycle; writes of 1 clear.
// A set wins over a clear in the same cycle (level semantics).
module irqc_pend
    import irqc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0][WORD_W-1:0] set_w,
    input  logic [1:0][WORD_W-1:0] clr_w,
    output logic [1:0][WORD_W-1:0] pend_w
);

    for (genvar w = 0; w < 2; w++) begin : g_word
        // Hold, clear on write-one, then set from the live level.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_w[w] <= '0;
            else        pend_w[w] <= (pend_w[w] & ~clr_w[w]) | set_w[w];
        end

        // R4: a clear without a competing set leaves the bit cleared.
        a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (|(clr_w[w] & ~set_w[w])) |=> ((pend_w[w] & $past(clr_w[w] & ~set_w[w])) == '0));
        // R5: a sampled high level is pending one cycle later.
        a_r5_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (|set_w[w]) |=> ((pend_w[w] & $past(set_w[w])) == $past(set_w[w])));
        // R4: with no set and no clear, the word holds.
        a_r4_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (set_w[w] == '0 && clr_w[w] == '0) |=> $stable(pend_w[w]));
    end

endmodule

// File: rtl/irqc_prio.sv
// Module: fixed-order selector. Reports the lowest active source number,
// ignoring source 0; outputs 0 when none of 1..63 is active.
// Clock and reset serve the assertions only.
module irqc_prio
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  act_src,
    output logic [NUM_W-1:0] win_num
);

    // Scan downward so the lowest active number is the last assignment.
    always_comb begin
        win_num = '0;
        for (int i = NSRC - 1; i >= 1; i--) begin
            if (act_src[i]) win_num = NUM_W'(i);
        end
    end

    // R8: a reported number is really active.
    a_r8_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
        (win_num != '0) |-> act_src[win_num]);
    // R8: no active source between 1 and the winner.
    a_r8_none_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (win_num != '0) |-> ((act_src & ((64'd1 << win_num) - 64'd1) & ~64'd1) == '0));
    // R7: a zero result means nothing in 1..63 is active.
    a_r7_zero_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (win_num == '0) |-> ((act_src & ~64'd1) == '0));

endmodule

// File: rtl/irqc_top.sv
// Module: register file, bus decode and request output for the masked
// vectored interrupt controller. Byte addressed, word-aligned accesses only;
// read data is combinational from the address.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter logic [31:0] CFG_RST  = 32'h0000_0000,
    parameter logic [31:0] PRIO_RST = 32'h0530_9770
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_req
);

    localparam int SEL_W = ADDR_W - 2;

    logic                   aligned;
    reg_sel_e               sel;
    logic                   wr;
    logic [WORD_W-1:0]      cfg_q, prio_up_q, prio_lo_q, en_up_q, en_lo_q;
    logic [WORD_W-1:0]      lvl_up, lvl_lo;
    logic [1:0][WORD_W-1:0] set_w, clr_w, pend_w;
    logic [NSRC-1:0]        act_src;
    logic [NUM_W-1:0]       win_num;
    logic [WORD_W-1:0]      vec_word;

    // Decode the word select and alignment.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        sel     = reg_sel_e'(bus_addr[ADDR_W-1 -: SEL_W]);
        wr      = bus_we && aligned;
    end

    // Writable storage and enable words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= CFG_RST;
            prio_up_q <= PRIO_RST;
            prio_lo_q <= PRIO_RST;
            en_up_q   <= '0;
            en_lo_q   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CFG:     cfg_q     <= bus_wdata;
                SEL_PRIO_UP: prio_up_q <= bus_wdata;
                SEL_PRIO_LO: prio_lo_q <= bus_wdata;
                SEL_EN_UP:   en_up_q   <= bus_wdata;
                SEL_EN_LO:   en_lo_q   <= bus_wdata;
                default:     ;
            endcase
        end
    end

    irqc_map i_map (
        .src_lvl (src_lvl),
        .act_up  (pend_w[1] & en_up_q),
        .act_lo  (pend_w[0] & en_lo_q),
        .lvl_up  (lvl_up),
        .lvl_lo  (lvl_lo),
        .act_src (act_src)
    );

    // Set and clear vectors per word (index 1 upper, 0 lower).
    always_comb begin
        set_w[1] = lvl_up;
        set_w[0] = lvl_lo;
        clr_w[1] = (wr && sel == SEL_PEND_UP) ? bus_wdata : '0;
        clr_w[0] = (wr && sel == SEL_PEND_LO) ? bus_wdata : '0;
    end

    irqc_pend i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_w  (set_w),
        .clr_w  (clr_w),
        .pend_w (pend_w)
    );

    irqc_prio i_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_src (act_src),
        .win_num (win_num)
    );

    // Pack the selected number into the top bits of the vector word.
    always_comb vec_word = {win_num, {(WORD_W - NUM_W){1'b0}}};

    // Read mux; misaligned reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (sel)
                SEL_CFG:     bus_rdata = cfg_q;
                SEL_PRIO_UP: bus_rdata = prio_up_q;
                SEL_PRIO_LO: bus_rdata = prio_lo_q;
                SEL_PEND_UP: bus_rdata = pend_w[1];
                SEL_PEND_LO: bus_rdata = pend_w[0];
                SEL_EN_UP:   bus_rdata = en_up_q;
                SEL_EN_LO:   bus_rdata = en_lo_q;
                SEL_VEC:     bus_rdata = vec_word;
                default:     bus_rdata = '0;
            endcase
        end
    end

    // Request whenever any pending bit meets its enable bit.
    always_comb irq_req = |((pend_w[1] & en_up_q) | (pend_w[0] & en_lo_q));

    // R3: enable words are cleared by reset.
    a_r3_enable_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_up_q == '0 && en_lo_q == '0));
    // R9: a nonzero vector always comes with a request.
    a_r9_vector_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (win_num != '0) |-> irq_req);
    // R3: a request needs at least one enable bit.
    a_r3_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en_up_q != '0 || en_lo_q != '0));
    // R6: no write reaches storage through the vector address.
    a_r6_vec_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && aligned && sel == SEL_VEC) |=> ($stable(en_up_q) && $stable(en_lo_q) && $stable(cfg_q)));

endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_lvl = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard queues: kind 0 = read data, kind 1 = request line.
    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_msg[$];

    localparam logic [4:0] A_CFG = 5'h00, A_PUP = 5'h04, A_PLO = 5'h08,
                           A_NUP = 5'h0C, A_NLO = 5'h10, A_EUP = 5'h14,
                           A_ELO = 5'h18, A_VEC = 5'h1C;

    always #2 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    // Monitor: pop expectations and compare away from the active edge.
    always @(negedge clk) begin
        while (q_kind.size() > 0) begin
            int          k;
            logic [31:0] e;
            logic [31:0] a;
            string       m;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            m = q_msg.pop_front();
            a = (k == 0) ? bus_rdata : {31'd0, irq_req};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", m, a, e);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string m);
        @(posedge clk); #1;
        bus_addr = a;
        q_kind.push_back(0); q_exp.push_back(e); q_msg.push_back(m);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string m);
        @(posedge clk); #1;
        q_kind.push_back(1); q_exp.push_back({31'd0, e}); q_msg.push_back(m);
        @(negedge clk);
    endtask

    task automatic set_src(input logic [63:0] v);
        @(posedge clk); #1;
        src_lvl = v;
    endtask

    task automatic clear_all();
        set_src('0);
        wr(A_NUP, 32'hFFFF_FFFF);
        wr(A_NLO, 32'hFFFF_FFFF);
    endtask

    // Expected word and bit of a source, from R1 and R2.
    function automatic void loc(input int s, output bit up, output int b);
        if (s < 16)      begin up = 1; b = (s == 0) ? 0 : 16 - s; end
        else if (s < 32) begin
            up = 0;
            if (s <= 18)      b = 18 - s;
            else if (s <= 30) b = 33 - s;
            else              b = 15;
        end
        else if (s < 48) begin up = 1; b = 63 - s; end
        else             begin up = 0; b = s - 32; end
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 / R3 / R7 / R9: reset state
        rd(A_CFG, 32'h0, "R10 cfg reset");
        rd(A_PUP, 32'h0530_9770, "R10 prio upper reset");
        rd(A_PLO, 32'h0530_9770, "R10 prio lower reset");
        rd(A_EUP, 32'h0, "R3 enable upper reset");
        rd(A_ELO, 32'h0, "R3 enable lower reset");
        rd(A_NUP, 32'h0, "R4 pending upper reset");
        rd(A_VEC, 32'h0, "R7 vector reset");
        chk_irq(1'b0, "R9 request reset");

        // R1 / R2 / R5: scatter of every source, masked (R3 blocks request)
        for (int s = 0; s < 64; s++) begin
            bit          up;
            int          b;
            logic [63:0] one;
            loc(s, up, b);
            one = '0; one[s] = 1'b1;
            set_src(one);
            rd(A_NUP, up ? (32'd1 << b) : 32'd0, $sformatf("R1 upper word src %0d", s));
            rd(A_NLO, up ? 32'd0 : (32'd1 << b), $sformatf("R2 lower word src %0d", s));
            chk_irq(1'b0, $sformatf("R3 disabled src %0d", s));
            clear_all();
        end

        // R4: write-one clears, zero holds, all ones clears all
        set_src((64'd1 << 5) | (64'd1 << 40));
        set_src('0);
        rd(A_NUP, 32'h0080_0800, "R4 two pending");
        wr(A_NUP, 32'h0);
        rd(A_NUP, 32'h0080_0800, "R4 zero write holds");
        wr(A_NUP, 32'h0000_0800);
        rd(A_NUP, 32'h0080_0000, "R4 single clear");
        wr(A_NUP, 32'hFFFF_FFFF);
        rd(A_NUP, 32'h0, "R4 all ones clear");

        // R5: live level survives a clear
        set_src(64'd1 << 20);
        wr(A_NLO, 32'hFFFF_FFFF);
        rd(A_NLO, 32'h0000_2000, "R5 level reasserts");
        clear_all();
        rd(A_NLO, 32'h0, "R5 cleared after drop");

        // R8 / R9 / R6: vector with sources 7 and 40 enabled
        wr(A_EUP, 32'h0080_0200);
        rd(A_EUP, 32'h0080_0200, "R3 enable readback");
        set_src((64'd1 << 7) | (64'd1 << 40));
        set_src('0);
        rd(A_VEC, 32'h1C00_0000, "R8 src 7 wins");
        chk_irq(1'b1, "R9 request with enabled pending");
        wr(A_NUP, 32'h0000_0200);
        rd(A_VEC, 32'hA000_0000, "R8 src 40 next");
        wr(A_EUP, 32'h0);
        rd(A_VEC, 32'h0, "R7 disabled gives zero");
        chk_irq(1'b0, "R3 disable drops request");
        rd(A_NUP, 32'h0080_0000, "R3 pending kept while disabled");
        clear_all();

        // R7 / R9: source 0 alone
        wr(A_EUP, 32'h0000_0001);
        set_src(64'd1);
        set_src('0);
        chk_irq(1'b1, "R9 source 0 requests");
        rd(A_VEC, 32'h0, "R7 source 0 vector zero");
        clear_all();

        // R8: priority across both words
        wr(A_EUP, 32'hFFFF_FFFF);
        wr(A_ELO, 32'hFFFF_FFFF);
        set_src((64'd1 << 63) | (64'd1 << 17) | (64'd1 << 33));
        set_src('0);
        rd(A_VEC, 32'h4400_0000, "R8 src 17 lowest");
        wr(A_NLO, 32'h0000_0002);
        rd(A_VEC, 32'h8400_0000, "R8 src 33 after clear");

        // R6: vector write ignored, reads inert
        wr(A_VEC, 32'hFFFF_FFFF);
        rd(A_VEC, 32'h8400_0000, "R6 write ignored");
        rd(A_VEC, 32'h8400_0000, "R6 reread stable");
        rd(A_NUP, 32'h4000_0000, "R6 read leaves pending");
        rd(A_EUP, 32'hFFFF_FFFF, "R6 enable intact");

        // R11: misaligned access
        wr(5'h15, 32'h0);
        rd(A_EUP, 32'hFFFF_FFFF, "R11 misaligned write dropped");
        rd(5'h15, 32'h0, "R11 misaligned read zero");

        // R10: storage registers read back
        wr(A_CFG, 32'h1234_5678);
        wr(A_PUP, 32'hCAFE_0001);
        wr(A_PLO, 32'h0BAD_F00D);
        rd(A_CFG, 32'h1234_5678, "R10 cfg readback");
        rd(A_PUP, 32'hCAFE_0001, "R10 prio upper readback");
        rd(A_PLO, 32'h0BAD_F00D, "R10 prio lower readback");

        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule